// File: doc/BRIEF.md
# String Compare Sequencer

This unit carries out one memory string-compare step, or a repeated run of them. On a start strobe it captures two pointers, a count and a configuration. It then reads one element at the source pointer and one at the destination pointer through a synchronous read port. It subtracts the destination element from the source element at the selected width and keeps only the status flags of that difference. After each comparison both pointers move together by the element size, upward or downward as the direction input selects. Nothing is ever written to memory.

With no repeat mode the unit performs exactly one comparison and raises `done`, so outside control can test the flags before it issues the next step. With one of the two repeat modes the unit loops by itself. It decrements the count after each comparison and stops when the count runs out or when the zero flag ends the run. The updated pointers, count and flags stay on the outputs until the next start.

Top module: `strcmp_seq`

## Requirements
- R1: After a comparison, `flags_out` holds the flags of source element minus destination element at the element width. The bit order is {overflow, sign, zero, aux, parity, carry} from bit 5 down to bit 0. Carry is the unsigned borrow. Aux is the borrow out of bit 3. Parity is 1 when the low 8 result bits have an even number of ones.
- R2: Each comparison makes exactly two reads with `mem_rd` high, the source address first and the destination address in the next cycle. Read data is little-endian and arrives one cycle after its address. `mem_rd` is low while `done` is high.
- R3: The element size code `elem_sz` 0, 1, 2 or 3 selects 1, 2, 4 or 8 bytes. Both pointers move by exactly that many bytes per comparison.
- R4: With `dir` = 0 both pointers increase, and with `dir` = 1 both decrease, in the same cycle and by the same amount.
- R5: With `addr32` = 1, pointer arithmetic wraps modulo 2^32. Bits 63:32 of each updated pointer are zero, and so are bits 63:32 of `mem_addr` during reads.
- R6: With `addr32` = 0, pointer arithmetic wraps modulo 2^64.
- R7: With `rep_mode` = 0 (or 3), exactly one comparison is made and `cnt_out` keeps the captured count. `done` is a single-cycle pulse.
- R8: With `rep_mode` = 1 (repeat while equal), the count drops by one per comparison. The run stops when the count reaches zero or when a comparison clears the zero flag.
- R9: With `rep_mode` = 2 (repeat while not equal), the count drops by one per comparison. The run stops when the count reaches zero or when a comparison sets the zero flag.
- R10: A repeated start with a zero count makes no reads. It leaves the pointers and flags as they were and raises `done` in the cycle right after the start is taken.
- R11: `elem_sz` = 3 with `wide_op` = 0 is not legal. The unit makes no reads, leaves the pointers and flags as they were, and raises `done` in the next cycle.
- R12: After reset, `done`, `mem_rd`, the flags, the pointers and the count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| elem_sz | input | 2 | Element size code: 0=1, 1=2, 2=4, 3=8 bytes |
| dir | input | 1 | 0 = pointers step up, 1 = step down |
| addr32 | input | 1 | 1 = 32-bit address arithmetic |
| wide_op | input | 1 | 64-bit operand mode; needed for 8-byte elements |
| rep_mode | input | 2 | 0/3 single, 1 repeat while equal, 2 repeat while not equal |
| src_in | input | ADDR_W | Initial source pointer |
| dst_in | input | ADDR_W | Initial destination pointer |
| cnt_in | input | CNT_W | Initial repeat count |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 64 | Read data, one cycle after the address, little-endian |
| src_out | output | ADDR_W | Current source pointer |
| dst_out | output | ADDR_W | Current destination pointer |
| cnt_out | output | CNT_W | Current count |
| flags_out | output | 6 | {of, sf, zf, af, pf, cf} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with the default 64-bit address width, so both the 2^32 and the 2^64 wrap points are reachable, and with a 16-bit count, which keeps repeat runs short. The memory model returns a background pattern around every element. This shows whether the flags ignore bytes above the selected width. Pointers placed just below 2^32 with garbage in the upper half expose the 32-bit masking on the pointers and on the read address.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    localparam int NUM_SZ = 4;
    localparam int MAX_BYTES = 1 << (NUM_SZ - 1);
    localparam int OPND_W = 8 * MAX_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_SRC = 3'd1,
        ST_RD_DST = 3'd2,
        ST_CMP    = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        RP_ONCE = 2'd0,
        RP_EQ   = 2'd1,
        RP_NE   = 2'd2
    } rep_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef struct packed {
        logic [1:0] sz;
        logic       dir;
        logic       a32;
        rep_e       rep;
    } cfg_t;

endpackage

// File: rtl/strcmp_flagcalc.sv
module strcmp_flagcalc
    import strcmp_pkg::*;
(
    input  logic [1:0]        sz,
    input  logic [OPND_W-1:0] opa,
    input  logic [OPND_W-1:0] opb,
    output flags_t            flags
);
    logic [OPND_W-1:0] diff;
    logic [NUM_SZ-1:0] cf_w;
    logic [NUM_SZ-1:0] zf_w;
    logic [NUM_SZ-1:0] sf_w;
    logic [NUM_SZ-1:0] of_w;
    logic [OPND_W-1:0] carries;

    assign diff    = opa - opb;
    assign carries = opa ^ opb ^ diff;

    for (genvar i = 0; i < NUM_SZ; i++) begin : g_width
        localparam int W = 8 << i;
        assign cf_w[i] = opa[W-1:0] < opb[W-1:0];
        assign zf_w[i] = diff[W-1:0] == '0;
        assign sf_w[i] = diff[W-1];
        assign of_w[i] = (opa[W-1] ^ opb[W-1]) & (diff[W-1] ^ opa[W-1]);
    end

    always_comb begin
        flags.cf = cf_w[sz];
        flags.zf = zf_w[sz];
        flags.sf = sf_w[sz];
        flags.of = of_w[sz];
        flags.af = carries[4];
        flags.pf = ~^diff[7:0];
    end

endmodule

// File: rtl/strcmp_ptr_step.sv
module strcmp_ptr_step #(
    parameter int ADDR_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [1:0]        sz,
    input  logic              dir,
    input  logic              a32,
    output logic [ADDR_W-1:0] nxt
);
    localparam int HI_W = ADDR_W - LOW_W;

    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        stride = ADDR_W'(1) << sz;
        sum    = dir ? (ptr - stride) : (ptr + stride);
        nxt    = a32 ? {{HI_W{1'b0}}, sum[LOW_W-1:0]} : sum;
    end

endmodule

// File: rtl/strcmp_seq.sv
module strcmp_seq
    import strcmp_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        elem_sz,
    input  logic              dir,
    input  logic              addr32,
    input  logic              wide_op,
    input  logic [1:0]        rep_mode,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [OPND_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [5:0]        flags_out,
    output logic              done
);
    localparam int LOW_W = 32;
    localparam int HI_W  = ADDR_W - LOW_W;

    typedef struct packed {
        state_e            st;
        cfg_t              cfg;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        flags_t            fl;
        logic [OPND_W-1:0] opa;
    } regs_t;

    regs_t r_d, r_q;

    logic              busy;
    logic              st_cmp;
    logic              cfg_a32;
    logic              cfg_dir;
    logic [1:0]        cfg_sz;
    logic [ADDR_W-1:0] src_nx;
    logic [ADDR_W-1:0] dst_nx;
    logic [CNT_W-1:0]  cnt_dec;
    flags_t            fl_new;
    rep_e              rep_norm;
    logic              keep_going;

    assign busy    = r_q.st != ST_IDLE;
    assign st_cmp  = r_q.st == ST_CMP;
    assign cfg_a32 = r_q.cfg.a32;
    assign cfg_dir = r_q.cfg.dir;
    assign cfg_sz  = r_q.cfg.sz;
    assign cnt_dec = r_q.cnt - CNT_W'(1);

    strcmp_flagcalc u_flags (
        .sz    (r_q.cfg.sz),
        .opa   (r_q.opa),
        .opb   (mem_rdata),
        .flags (fl_new)
    );

    strcmp_ptr_step #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_src_step (
        .ptr (r_q.src),
        .sz  (r_q.cfg.sz),
        .dir (r_q.cfg.dir),
        .a32 (r_q.cfg.a32),
        .nxt (src_nx)
    );

    strcmp_ptr_step #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_dst_step (
        .ptr (r_q.dst),
        .sz  (r_q.cfg.sz),
        .dir (r_q.cfg.dir),
        .a32 (r_q.cfg.a32),
        .nxt (dst_nx)
    );

    always_comb begin
        case (rep_mode)
            2'd1:    rep_norm = RP_EQ;
            2'd2:    rep_norm = RP_NE;
            default: rep_norm = RP_ONCE;
        endcase
    end

    always_comb begin
        case (r_q.cfg.rep)
            RP_EQ:   keep_going = (cnt_dec != '0) && fl_new.zf;
            RP_NE:   keep_going = (cnt_dec != '0) && !fl_new.zf;
            default: keep_going = 1'b0;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        mem_rd   = 1'b0;
        mem_addr = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cfg.sz  = elem_sz;
                    r_d.cfg.dir = dir;
                    r_d.cfg.a32 = addr32;
                    r_d.cfg.rep = rep_norm;
                    r_d.src     = src_in;
                    r_d.dst     = dst_in;
                    r_d.cnt     = cnt_in;
                    if (elem_sz == 2'd3 && !wide_op) begin
                        r_d.st = ST_DONE;
                    end else if (rep_norm != RP_ONCE && cnt_in == '0) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.st = ST_RD_SRC;
                    end
                end
            end
            ST_RD_SRC: begin
                mem_rd   = 1'b1;
                mem_addr = r_q.cfg.a32 ? {{HI_W{1'b0}}, r_q.src[LOW_W-1:0]} : r_q.src;
                r_d.st   = ST_RD_DST;
            end
            ST_RD_DST: begin
                mem_rd   = 1'b1;
                mem_addr = r_q.cfg.a32 ? {{HI_W{1'b0}}, r_q.dst[LOW_W-1:0]} : r_q.dst;
                r_d.opa  = mem_rdata;
                r_d.st   = ST_CMP;
            end
            ST_CMP: begin
                r_d.fl  = fl_new;
                r_d.src = src_nx;
                r_d.dst = dst_nx;
                if (r_q.cfg.rep != RP_ONCE) begin
                    r_d.cnt = cnt_dec;
                end
                r_d.st = keep_going ? ST_RD_SRC : ST_DONE;
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_out   = r_q.src;
    assign dst_out   = r_q.dst;
    assign cnt_out   = r_q.cnt;
    assign flags_out = r_q.fl;
    assign done      = r_q.st == ST_DONE;

endmodule

// File: rtl/strcmp_seq_chk.sv
module strcmp_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        elem_sz,
    input logic              wide_op,
    input logic [1:0]        rep_mode,
    input logic [CNT_W-1:0]  cnt_in,
    input logic              busy,
    input logic              st_cmp,
    input logic              cfg_a32,
    input logic              cfg_dir,
    input logic [1:0]        cfg_sz,
    input logic [ADDR_W-1:0] src_out,
    input logic [ADDR_W-1:0] dst_out,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);
    logic zero_rep_start;
    logic bad_size_start;

    assign zero_rep_start = !busy && start && (rep_mode == 2'd1 || rep_mode == 2'd2)
                            && cnt_in == '0;
    assign bad_size_start = !busy && start && elem_sz == 2'd3 && !wide_op;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_read_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd);

    assert_addr_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && cfg_a32) |-> (mem_addr[ADDR_W-1:32] == '0));

    assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rep_start |=> (done && !mem_rd));

    assert_bad_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_size_start |=> (done && !mem_rd));

    assert_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cmp && !cfg_a32) |=>
            ((src_out - $past(src_out)) == (dst_out - $past(dst_out))));

    assert_stride_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cmp && !cfg_a32 && !cfg_dir) |=>
            ((src_out - $past(src_out)) == (ADDR_W'(1) << cfg_sz)));

endmodule

bind strcmp_seq strcmp_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .elem_sz  (elem_sz),
    .wide_op  (wide_op),
    .rep_mode (rep_mode),
    .cnt_in   (cnt_in),
    .busy     (busy),
    .st_cmp   (st_cmp),
    .cfg_a32  (cfg_a32),
    .cfg_dir  (cfg_dir),
    .cfg_sz   (cfg_sz),
    .src_out  (src_out),
    .dst_out  (dst_out),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/strcmp_seq_tb.sv
module strcmp_seq_tb;

    localparam int AW = 64;
    localparam int CW = 16;

    typedef struct packed {
        logic [1:0]  sz;
        logic        dir;
        logic [63:0] a;
        logic [63:0] b;
        logic [5:0]  fl;
    } vec_t;

    // flags {of, sf, zf, af, pf, cf}
    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 64'h05, 64'h05, 6'b001010},
        '{2'd0, 1'b1, 64'h00, 64'h01, 6'b010111},
        '{2'd0, 1'b0, 64'h80, 64'h01, 6'b100100},
        '{2'd1, 1'b1, 64'h0100, 64'h0001, 6'b000110},
        '{2'd2, 1'b0, 64'h0, 64'h8000_0000, 6'b110011},
        '{2'd3, 1'b1, 64'h8000_0000_0000_0000, 64'h0, 6'b010010},
        '{2'd0, 1'b1, 64'h7F, 64'hFF, 6'b110001},
        '{2'd1, 1'b0, 64'h0000, 64'hFFFF, 6'b000101}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    elem_sz = '0;
    logic          dir = 1'b0;
    logic          addr32 = 1'b0;
    logic          wide_op = 1'b1;
    logic [1:0]    rep_mode = '0;
    logic [AW-1:0] src_in = '0;
    logic [AW-1:0] dst_in = '0;
    logic [CW-1:0] cnt_in = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_rdata = '0;
    logic [AW-1:0] src_out;
    logic [AW-1:0] dst_out;
    logic [CW-1:0] cnt_out;
    logic [5:0]    flags_out;
    logic          done;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    logic [7:0]  mem [256];
    logic [63:0] rd_log [1024];

    always #4 clk = ~clk;

    strcmp_seq #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_sz(elem_sz), .dir(dir),
        .addr32(addr32), .wide_op(wide_op), .rep_mode(rep_mode), .src_in(src_in),
        .dst_in(dst_in), .cnt_in(cnt_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .src_out(src_out), .dst_out(dst_out),
        .cnt_out(cnt_out), .flags_out(flags_out), .done(done)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            for (int i = 0; i < 8; i++) begin
                mem_rdata[8*i +: 8] <= mem[8'(mem_addr[7:0] + 8'(i))];
            end
            rd_log[rd_cnt % 1024] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill_bg();
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    endtask

    task automatic put(input logic [63:0] addr, input logic [63:0] val, input int nb);
        for (int i = 0; i < nb; i++) mem[8'(addr[7:0] + 8'(i))] = val[8*i +: 8];
    endtask

    function automatic logic [63:0] step(input logic [63:0] p, input logic [1:0] sz,
                                         input logic d);
        return d ? p - (64'd1 << sz) : p + (64'd1 << sz);
    endfunction

    int base;
    int waits;

    task automatic run_op(input logic [1:0] sz, input logic d, input logic a32,
                          input logic wide, input logic [1:0] rep,
                          input logic [63:0] s, input logic [63:0] ds,
                          input logic [15:0] c);
        @(negedge clk);
        elem_sz = sz; dir = d; addr32 = a32; wide_op = wide; rep_mode = rep;
        src_in = s; dst_in = ds; cnt_in = c; start = 1'b1;
        base = rd_cnt;
        @(negedge clk);
        start = 1'b0;
        waits = 0;
        while (!done && waits < 500) begin
            @(negedge clk);
            waits++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog operation never completed actual=0 expected=1");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run hung actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] fl_before;
        fill_bg();
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "done", 64'(done), 64'd0);
        check("R12", "mem_rd", 64'(mem_rd), 64'd0);
        check("R12", "flags", 64'(flags_out), 64'd0);
        check("R12", "src", src_out, 64'd0);
        check("R12", "cnt", 64'(cnt_out), 64'd0);
        rst_n = 1'b1;

        // single comparisons from the vector table: R1 R2 R3 R4 R7
        foreach (VECS[k]) begin
            int nb;
            nb = 1 << VECS[k].sz;
            fill_bg();
            put(64'h40, VECS[k].a, nb);
            put(64'h80, VECS[k].b, nb);
            run_op(VECS[k].sz, VECS[k].dir, 1'b0, 1'b1, 2'd0, 64'h40, 64'h80, 16'd7);
            check("R1", "flags", 64'(flags_out), 64'(VECS[k].fl));
            check("R3", "src step", src_out, step(64'h40, VECS[k].sz, VECS[k].dir));
            check("R4", "dst step", dst_out, step(64'h80, VECS[k].sz, VECS[k].dir));
            check("R7", "count kept", 64'(cnt_out), 64'd7);
            check("R2", "read count", 64'(rd_cnt - base), 64'd2);
            check("R2", "first read", rd_log[base % 1024], 64'h40);
            check("R2", "second read", rd_log[(base + 1) % 1024], 64'h80);
            @(negedge clk);
            check("R7", "done pulse", 64'(done), 64'd0);
        end

        // R8 repeat while equal, mismatch at 5th element
        fill_bg();
        put(64'h40, 64'h09_04_03_02_01, 5);
        put(64'h80, 64'h05_04_03_02_01, 5);
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 64'h40, 64'h80, 16'd10);
        check("R8", "count", 64'(cnt_out), 64'd5);
        check("R8", "src", src_out, 64'h45);
        check("R8", "flags", 64'(flags_out), 64'(6'b000000));
        check("R8", "reads", 64'(rd_cnt - base), 64'd10);

        // R8 repeat while equal, count exhausted, word size going down
        fill_bg();
        put(64'h3E, 64'hBEEF_1234, 4);
        put(64'h7E, 64'hBEEF_1234, 4);
        run_op(2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 64'h40, 64'h80, 16'd2);
        check("R8", "count", 64'(cnt_out), 64'd0);
        check("R8", "src", src_out, 64'h3C);
        check("R8", "dst", dst_out, 64'h7C);
        check("R8", "flags", 64'(flags_out), 64'(6'b001010));

        // R9 repeat while not equal, stops on match
        fill_bg();
        put(64'h40, 64'h03_02_01, 3);
        put(64'h80, 64'h03_06_05, 3);
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 64'h40, 64'h80, 16'd8);
        check("R9", "count", 64'(cnt_out), 64'd5);
        check("R9", "dst", dst_out, 64'h83);
        check("R9", "flags", 64'(flags_out), 64'(6'b001010));

        // R9 count exhausted with no match
        fill_bg();
        put(64'h40, 64'h0302, 2);
        put(64'h80, 64'h0605, 2);
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 64'h40, 64'h80, 16'd2);
        check("R9", "count", 64'(cnt_out), 64'd0);
        check("R9", "src", src_out, 64'h42);

        // R10 zero count
        fl_before = flags_out;
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 64'h1234, 64'h5678, 16'd0);
        check("R10", "latency", 64'(waits), 64'd0);
        check("R10", "reads", 64'(rd_cnt - base), 64'd0);
        check("R10", "src", src_out, 64'h1234);
        check("R10", "dst", dst_out, 64'h5678);
        check("R10", "flags", 64'(flags_out), 64'(fl_before));

        // R11 eight-byte element without 64-bit operand mode
        fl_before = flags_out;
        run_op(2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 64'h200, 64'h300, 16'd4);
        check("R11", "latency", 64'(waits), 64'd0);
        check("R11", "reads", 64'(rd_cnt - base), 64'd0);
        check("R11", "src", src_out, 64'h200);
        check("R11", "flags", 64'(flags_out), 64'(fl_before));

        // R5 32-bit wrap upward with garbage in upper half
        fill_bg();
        run_op(2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 64'h1234_5678_FFFF_FFFF,
               64'h0000_0000_FFFF_FFFE, 16'd1);
        check("R5", "src wrap", src_out, 64'h0);
        check("R5", "dst", dst_out, 64'h0000_0000_FFFF_FFFF);
        check("R5", "read addr", rd_log[base % 1024], 64'h0000_0000_FFFF_FFFF);

        // R5 32-bit wrap downward, qword
        run_op(2'd3, 1'b1, 1'b1, 1'b1, 2'd0, 64'hABCD_0000_0000_0000,
               64'h0000_0000_0000_0010, 16'd1);
        check("R5", "src wrap down", src_out, 64'h0000_0000_FFFF_FFF8);
        check("R5", "dst", dst_out, 64'h0000_0000_0000_0008);

        // R6 64-bit wrap
        run_op(2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'd1);
        check("R6", "src wrap", src_out, 64'hFFFF_FFFF_FFFF_FFFC);
        check("R6", "dst", dst_out, 64'hFFFF_FFFF_FFFF_FFFB);
        run_op(2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, 16'd1);
        check("R6", "src wrap up", src_out, 64'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule